// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one capture/compare slice that sits beside a free-running timer counter. It owns one channel register. In compare mode the channel watches the shared count and raises a one-cycle equal event when the count first reaches the register value. It then drives a pin through one of eight output behaviours. These combine its own equal event with the period event that the timer's first channel broadcasts.

In capture mode the channel picks one of four input sources: two external pins, a fixed low or a fixed high. It passes the chosen source through a synchroniser and looks for the configured edges. It then copies the live count into the channel register. Capture can be taken as soon as the edge is seen, or held until the next timer advance strobe so that it lines up with the timer clock. A sticky overflow flag records any capture taken while the previous event was still unserviced.

Top module: `tmr_cc_channel`

## Requirements
- R1: While rst_n is low, pin_o, evt_flag_o, lost_o, irq_o, cci_latched_o and cmp_val_o all read 0.
- R2: With mode_cap_i = 0 (compare), equ_o is high in the first cycle in which count_i equals cmp_val_o, and evt_flag_o is 1 after the next edge. While count_i holds at that value, equ_o stays low.
- R3: src_sel_i selects the channel input: 0 = src_a_i, 1 = src_b_i, 2 = constant 0, 3 = constant 1. cci_o shows the selected value in the same cycle. Switching between codes 2 and 3 forces a capture edge.
- R4: With mode_cap_i = 1, edge_sel_i picks the capture edges: 0 none, 1 rising, 2 falling, 3 both. Edges not selected are ignored. With sync_en_i = 0, a capture lands on the (SYNC_STAGES+1)-th rising clock edge after the input changes, and not earlier.
- R5: A capture copies count_i, as sampled at the capture edge, into cmp_val_o, and it sets evt_flag_o at that same edge.
- R6: With sync_en_i = 1, a detected edge is held until a cycle with tick_i = 1. The capture then takes the count of that cycle, and only one capture is made.
- R7: A capture taken while evt_flag_o is 1 sets lost_o. lost_o is cleared only by lost_clr_i; flag_clr_i leaves it unchanged.
- R8: flag_clr_i clears evt_flag_o unless a new event arrives in the same cycle. irq_o equals evt_flag_o gated by irq_en_i.
- R9: On every equal event, cci_latched_o takes the value of the selected input.
- R10: With out_mode_i = 0, pin_o follows out_bit_i one edge later.
- R11: out_mode_i 1 (set), 4 (toggle) and 5 (clear) act on the equal event only; the period event has no effect on them.
- R12: Paired modes act on the equal event first and on the period event second: 2 toggle/clear, 3 set/clear, 6 toggle/set, 7 clear/set. When both events coincide, the period action wins.
- R13: cmp_wr_i loads cmp_data_i into the channel register. If a capture happens in the same cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| count_i | input | CNT_W | Shared timer count |
| tick_i | input | 1 | Timer advance strobe |
| period_eq_i | input | 1 | Period event from channel 0 |
| src_a_i | input | 1 | External capture input A |
| src_b_i | input | 1 | External capture input B |
| mode_cap_i | input | 1 | 0 compare, 1 capture |
| edge_sel_i | input | 2 | Capture edge selection |
| src_sel_i | input | 2 | Input source selection |
| sync_en_i | input | 1 | Align capture to tick_i |
| out_mode_i | input | 3 | Output behaviour |
| out_bit_i | input | 1 | Software pin value for mode 0 |
| irq_en_i | input | 1 | Interrupt enable |
| cmp_wr_i | input | 1 | Channel register write strobe |
| cmp_data_i | input | CNT_W | Channel register write data |
| flag_clr_i | input | 1 | Clear event flag |
| lost_clr_i | input | 1 | Clear overflow flag |
| cmp_val_o | output | CNT_W | Channel register |
| equ_o | output | 1 | One-cycle equal event |
| pin_o | output | 1 | Output pin |
| cci_o | output | 1 | Selected input, unlatched |
| cci_latched_o | output | 1 | Selected input latched on equal |
| evt_flag_o | output | 1 | Channel event flag |
| irq_o | output | 1 | Interrupt request |
| lost_o | output | 1 | Capture overflow flag |

## Verification
The bench counts clock edges through the synchroniser and checks that no capture lands one edge early. A design with a shorter chain or a combinational capture path would fail that check. It holds the count on the compare value and looks for a second equal event; a level-based compare would keep retriggering the flag and would fail there. It forces the channel and period events to coincide in the paired output modes, where the wrong priority leaves the pin inverted. It also lines up a register write with a capture, and clears the event flag while the overflow flag is set. Random output-mode, count and period traffic is then checked against a bench model of the pin and flag.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_ANY  = 2'd3
   } edge_sel_e;

   typedef enum logic [1:0] {
      SRC_PIN_A = 2'd0,
      SRC_PIN_B = 2'd1,
      SRC_LOW   = 2'd2,
      SRC_HIGH  = 2'd3
   } src_sel_e;

   typedef enum logic [2:0] {
      OM_DIRECT  = 3'd0,
      OM_SET     = 3'd1,
      OM_TOG_CLR = 3'd2,
      OM_SET_CLR = 3'd3,
      OM_TOGGLE  = 3'd4,
      OM_CLEAR   = 3'd5,
      OM_TOG_SET = 3'd6,
      OM_CLR_SET = 3'd7
   } out_mode_e;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_SET  = 2'd1,
      ACT_CLR  = 2'd2,
      ACT_TOG  = 2'd3
   } pin_act_e;

   function automatic logic apply_act(input pin_act_e act, input logic cur);
      case (act)
         ACT_SET: return 1'b1;
         ACT_CLR: return 1'b0;
         ACT_TOG: return ~cur;
         default: return cur;
      endcase
   endfunction

endpackage

// File: rtl/tmr_cc_capture.sv
module tmr_cc_capture
   import tmr_cc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       src_a_i,
   input  logic       src_b_i,
   input  logic [1:0] src_sel_i,
   input  logic [1:0] edge_sel_i,
   input  logic       arm_i,
   input  logic       sync_en_i,
   input  logic       tick_i,
   output logic       sel_raw_o,
   output logic       fire_o
);

   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_stages
      $error("tmr_cc_capture: SYNC_STAGES must lie in 1..4");
   end

   logic             sel_raw;
   logic [LAST:0]    sync_q;
   logic             prev_q;
   logic             pend_q;
   logic             rise, fall, edge_hit, evt;

   always_comb begin
      case (src_sel_e'(src_sel_i))
         SRC_PIN_A: sel_raw = src_a_i;
         SRC_PIN_B: sel_raw = src_b_i;
         SRC_LOW:   sel_raw = 1'b0;
         default:   sel_raw = 1'b1;
      endcase
   end

   assign sel_raw_o = sel_raw;

   for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_sync
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= sel_raw;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[k] <= 1'b0;
            else        sync_q[k] <= sync_q[k-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[LAST];
   end

   assign rise = sync_q[LAST] & ~prev_q;
   assign fall = ~sync_q[LAST] & prev_q;

   always_comb begin
      case (edge_sel_e'(edge_sel_i))
         EDGE_RISE: edge_hit = rise;
         EDGE_FALL: edge_hit = fall;
         EDGE_ANY:  edge_hit = rise | fall;
         default:   edge_hit = 1'b0;
      endcase
   end

   assign evt    = arm_i & edge_hit;
   assign fire_o = arm_i & (sync_en_i ? (tick_i & (evt | pend_q)) : evt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      pend_q <= 1'b0;
      else if (!arm_i || !sync_en_i)   pend_q <= 1'b0;
      else if (fire_o)                 pend_q <= 1'b0;
      else if (evt)                    pend_q <= 1'b1;
   end

   // R6: a held edge stays held until the strobe arrives
   p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && arm_i && sync_en_i && !tick_i) |=> pend_q);

endmodule

// File: rtl/tmr_cc_outunit.sv
module tmr_cc_outunit
   import tmr_cc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode_i,
   input  logic       sw_bit_i,
   input  logic       own_evt_i,
   input  logic       per_evt_i,
   output logic       pin_o
);

   pin_act_e own_act, per_act;
   logic     pin_q, pin_d;

   always_comb begin
      own_act = ACT_HOLD;
      per_act = ACT_HOLD;
      case (out_mode_e'(mode_i))
         OM_SET:     own_act = ACT_SET;
         OM_TOGGLE:  own_act = ACT_TOG;
         OM_CLEAR:   own_act = ACT_CLR;
         OM_TOG_CLR: begin own_act = ACT_TOG; per_act = ACT_CLR; end
         OM_SET_CLR: begin own_act = ACT_SET; per_act = ACT_CLR; end
         OM_TOG_SET: begin own_act = ACT_TOG; per_act = ACT_SET; end
         OM_CLR_SET: begin own_act = ACT_CLR; per_act = ACT_SET; end
         default:    ;
      endcase
   end

   always_comb begin
      if (out_mode_e'(mode_i) == OM_DIRECT)             pin_d = sw_bit_i;
      else if (per_evt_i && per_act != ACT_HOLD)        pin_d = apply_act(per_act, pin_q);
      else if (own_evt_i)                               pin_d = apply_act(own_act, pin_q);
      else                                              pin_d = pin_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_d;
   end

   assign pin_o = pin_q;

   p_set_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd1 && own_evt_i) |=> pin_o);
   p_clr_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd5 && own_evt_i) |=> !pin_o);
   p_per_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd3 && per_evt_i) |=> !pin_o);
   p_per_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 3'd7 && per_evt_i) |=> pin_o);

endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel
   import tmr_cc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   input  logic             tick_i,
   input  logic             period_eq_i,
   input  logic             src_a_i,
   input  logic             src_b_i,
   input  logic             mode_cap_i,
   input  logic [1:0]       edge_sel_i,
   input  logic [1:0]       src_sel_i,
   input  logic             sync_en_i,
   input  logic [2:0]       out_mode_i,
   input  logic             out_bit_i,
   input  logic             irq_en_i,
   input  logic             cmp_wr_i,
   input  logic [CNT_W-1:0] cmp_data_i,
   input  logic             flag_clr_i,
   input  logic             lost_clr_i,
   output logic [CNT_W-1:0] cmp_val_o,
   output logic             equ_o,
   output logic             pin_o,
   output logic             cci_o,
   output logic             cci_latched_o,
   output logic             evt_flag_o,
   output logic             irq_o,
   output logic             lost_o
);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("tmr_cc_channel: CNT_W must lie in 2..32");
   end

   logic [CNT_W-1:0] cmp_q;
   logic             match_now, match_q, equ;
   logic             cap_fire, sel_raw;
   logic             flag_q, lost_q, latch_q;

   tmr_cc_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_a_i    (src_a_i),
      .src_b_i    (src_b_i),
      .src_sel_i  (src_sel_i),
      .edge_sel_i (edge_sel_i),
      .arm_i      (mode_cap_i),
      .sync_en_i  (sync_en_i),
      .tick_i     (tick_i),
      .sel_raw_o  (sel_raw),
      .fire_o     (cap_fire)
   );

   // equal event: first cycle of a match only
   assign match_now = ~mode_cap_i & (count_i == cmp_q);
   assign equ       = match_now & ~match_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= 1'b0;
      else        match_q <= match_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cmp_q <= '0;
      else if (cap_fire) cmp_q <= count_i;
      else if (cmp_wr_i) cmp_q <= cmp_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flag_q <= 1'b0;
      else if (cap_fire | equ) flag_q <= 1'b1;
      else if (flag_clr_i)     flag_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  lost_q <= 1'b0;
      else if (cap_fire && flag_q) lost_q <= 1'b1;
      else if (lost_clr_i)         lost_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   latch_q <= 1'b0;
      else if (equ) latch_q <= sel_raw;
   end

   tmr_cc_outunit u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (out_mode_i),
      .sw_bit_i  (out_bit_i),
      .own_evt_i (equ),
      .per_evt_i (period_eq_i),
      .pin_o     (pin_o)
   );

   assign cmp_val_o     = cmp_q;
   assign equ_o         = equ;
   assign cci_o         = sel_raw;
   assign cci_latched_o = latch_q;
   assign evt_flag_o    = flag_q;
   assign irq_o         = flag_q & irq_en_i;
   assign lost_o        = lost_q;

   p_cap_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_fire |=> (cmp_val_o == $past(count_i)) && evt_flag_o);
   p_equ_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      equ_o |=> evt_flag_o);
   p_lost_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_fire && evt_flag_o) |=> lost_o);
   p_lost_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_o && !lost_clr_i) |=> lost_o);
   p_cap_no_equ_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mode_cap_i |-> !equ_o);

endmodule

// File: tb/tmr_cc_channel_test.sv
module tmr_cc_channel_test;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] count = '0;
   logic         tick = 0, per = 0, a = 0, b = 0, capm = 0, sync_en = 0;
   logic [1:0]   edge_sel = 0, src_sel = 0;
   logic [2:0]   omode = 0;
   logic         obit = 0, irq_en = 0, cmp_wr = 0, fclr = 0, lclr = 0;
   logic [W-1:0] cmp_data = '0;
   logic [W-1:0] cmp_val;
   logic         equ, pin, cci, ccil, flag, irq, lost;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   tmr_cc_channel #(.CNT_W(W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .count_i(count), .tick_i(tick),
      .period_eq_i(per), .src_a_i(a), .src_b_i(b), .mode_cap_i(capm),
      .edge_sel_i(edge_sel), .src_sel_i(src_sel), .sync_en_i(sync_en),
      .out_mode_i(omode), .out_bit_i(obit), .irq_en_i(irq_en),
      .cmp_wr_i(cmp_wr), .cmp_data_i(cmp_data), .flag_clr_i(fclr),
      .lost_clr_i(lclr), .cmp_val_o(cmp_val), .equ_o(equ), .pin_o(pin),
      .cci_o(cci), .cci_latched_o(ccil), .evt_flag_o(flag), .irq_o(irq),
      .lost_o(lost)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic nx(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_flag();
      fclr = 1; nx(1); fclr = 0;
   endtask

   task automatic hit_equal(input logic [W-1:0] v);
      count = v - 1; nx(1); count = v; nx(1);
   endtask

   // bench model of the pin for a given mode and event pair
   function automatic logic pin_model(input logic [2:0] m, input logic sw,
                                      input logic own, input logic pe, input logic cur);
      logic r;
      r = cur;
      case (m)
         3'd0: r = sw;
         3'd1: if (own) r = 1'b1;
         3'd4: if (own) r = ~cur;
         3'd5: if (own) r = 1'b0;
         3'd2: if (pe) r = 1'b0; else if (own) r = ~cur;
         3'd3: if (pe) r = 1'b0; else if (own) r = 1'b1;
         3'd6: if (pe) r = 1'b1; else if (own) r = ~cur;
         default: if (pe) r = 1'b1; else if (own) r = 1'b0;
      endcase
      return r;
   endfunction

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      logic m_prev, m_pin, m_flag, m_equ;
      void'($urandom(32'd1234));
      nx(3);
      chk("R1 pin", pin, 0);  chk("R1 flag", flag, 0); chk("R1 lost", lost, 0);
      chk("R1 irq", irq, 0);  chk("R1 latch", ccil, 0); chk("R1 cmp", cmp_val, 0);
      rst_n = 1;

      // R3 input select
      a = 1; b = 0;
      src_sel = 0; #1 chk("R3 sel A", cci, 1);
      src_sel = 1; #1 chk("R3 sel B", cci, 0);
      src_sel = 2; #1 chk("R3 sel low", cci, 0);
      src_sel = 3; #1 chk("R3 sel high", cci, 1);
      nx(1); src_sel = 0; a = 0; nx(4);

      // R13 register write
      cmp_wr = 1; cmp_data = 16'h0050; nx(1); cmp_wr = 0;
      chk("R13 write", cmp_val, 16'h0050);
      clear_flag(); chk("R8 clear", flag, 0);

      // R2 equal event
      count = 16'h004F; nx(1); chk("R2 no match", flag, 0);
      count = 16'h0050; #1 chk("R2 equ pulse", equ, 1);
      nx(1); chk("R2 flag", flag, 1); chk("R2 single", equ, 0);
      nx(2); chk("R2 hold no refire", equ, 0);
      irq_en = 0; #1 chk("R8 irq off", irq, 0);
      irq_en = 1; #1 chk("R8 irq on", irq, 1);
      clear_flag(); chk("R8 cleared", flag, 0); chk("R8 irq low", irq, 0);
      irq_en = 0;

      // R9 latched input
      src_sel = 3; hit_equal(16'h0050); chk("R9 latch high", ccil, 1);
      src_sel = 2; hit_equal(16'h0050); chk("R9 latch low", ccil, 0);
      src_sel = 0; clear_flag(); nx(4);

      // R10 direct mode
      omode = 0; obit = 1; nx(1); chk("R10 direct 1", pin, 1);
      obit = 0; nx(1); chk("R10 direct 0", pin, 0);

      // R11 single-action modes
      omode = 1; hit_equal(16'h0050); chk("R11 set", pin, 1);
      per = 1; nx(1); per = 0; chk("R11 period ignored", pin, 1);
      omode = 5; hit_equal(16'h0050); chk("R11 clear", pin, 0);
      omode = 4; hit_equal(16'h0050); chk("R11 toggle", pin, 1);

      // R12 coincident events
      omode = 7; count = 16'h004F; nx(1);
      count = 16'h0050; per = 1; nx(1); per = 0; chk("R12 clr/set coincide", pin, 1);
      omode = 3; count = 16'h004F; nx(1);
      count = 16'h0050; per = 1; nx(1); per = 0; chk("R12 set/clr coincide", pin, 0);
      omode = 0; clear_flag();

      // R4/R5 asynchronous capture, rising edge
      capm = 1; edge_sel = 1; src_sel = 0; sync_en = 0; count = 16'h0111;
      a = 1; nx(2); chk("R4 not early", flag, 0);
      nx(1); chk("R5 flag", flag, 1); chk("R5 count", cmp_val, 16'h0111);
      a = 0; nx(3); chk("R4 fall ignored", cmp_val, 16'h0111); chk("R7 no lost", lost, 0);
      count = 16'h0222; a = 1; nx(3);
      chk("R5 second", cmp_val, 16'h0222); chk("R7 lost set", lost, 1);
      clear_flag(); chk("R7 flag clr keeps lost", lost, 1);
      lclr = 1; nx(1); lclr = 0; chk("R7 lost clr", lost, 0);

      // R4 falling edge
      edge_sel = 2; count = 16'h0333; a = 0; nx(3);
      chk("R4 falling", cmp_val, 16'h0333);
      clear_flag(); a = 1; nx(3); chk("R4 rise ignored", flag, 0);

      // R3 forced capture via constants, both edges
      edge_sel = 3; count = 16'h0444; src_sel = 2; nx(3);
      chk("R3 forced low", cmp_val, 16'h0444);
      clear_flag(); count = 16'h0555; src_sel = 3; nx(3);
      chk("R3 forced high", cmp_val, 16'h0555);
      clear_flag(); edge_sel = 0; src_sel = 2; nx(3);
      chk("R4 none", flag, 0); chk("R4 none cmp", cmp_val, 16'h0555);

      // R13 capture beats write
      edge_sel = 1; count = 16'h0666; src_sel = 3; nx(2);
      cmp_wr = 1; cmp_data = 16'h0ABC; nx(1); cmp_wr = 0;
      chk("R13 capture wins", cmp_val, 16'h0666);
      clear_flag();

      // R6 synchronised capture
      sync_en = 1; tick = 0; edge_sel = 3; count = 16'h0777; src_sel = 2; nx(5);
      chk("R6 held", flag, 0); chk("R6 held cmp", cmp_val, 16'h0666);
      count = 16'h0888; tick = 1; nx(1); tick = 0;
      chk("R6 on tick", cmp_val, 16'h0888); chk("R6 flag", flag, 1);
      count = 16'h0999; tick = 1; nx(2); tick = 0;
      chk("R6 single", cmp_val, 16'h0888);

      // random compare traffic
      capm = 0; sync_en = 0; edge_sel = 0; src_sel = 0;
      cmp_wr = 1; cmp_data = 16'h1234; fclr = 1; count = 0; omode = 0; obit = 0;
      nx(1); cmp_wr = 0; fclr = 0; nx(1);
      m_prev = 0; m_pin = 0; m_flag = 0;
      for (int i = 0; i < 300; i++) begin
         omode = 3'($urandom % 8);
         obit  = 1'($urandom % 2);
         per   = 1'($urandom % 2);
         fclr  = ($urandom % 4) == 0;
         count = ($urandom % 2) ? 16'h1234 : 16'h1235;
         m_equ  = (count == 16'h1234) && !m_prev;
         m_prev = (count == 16'h1234);
         m_pin  = pin_model(omode, obit, m_equ, per, m_pin);
         m_flag = m_equ ? 1'b1 : (fclr ? 1'b0 : m_flag);
         nx(1);
         if (omode == 0)                               chk("R10 random pin", pin, m_pin);
         else if (omode == 1 || omode == 4 || omode == 5) chk("R11 random pin", pin, m_pin);
         else                                          chk("R12 random pin", pin, m_pin);
         chk("R2 random flag", flag, m_flag);
      end
      per = 0; fclr = 0;
      finish_run();
   end

endmodule